// File: doc/BRIEF.md
# Synchronous Burst Write Controller for Pseudo-Static RAM

This block sits on the host side of a pseudo-static RAM with a synchronous burst interface and runs write bursts only. A user port hands over one request at a time with a valid/ready handshake. Each request carries a start address, a full burst of data words and two byte-enable bits per word. Once a request is accepted, the controller drives chip select, the address-valid strobe and write enable low together and places the address on the bus. It waits out the configured write latency and then streams one word per clock. Chip select is released after the last word and held high for a minimum gap before the next request is taken.

Individual words can be suppressed without changing the burst timing: when both byte-enable bits of a word are clear, both byte strobes stay inactive during that word's slot. A cycle limit on the time chip select is low is computed from the clock period and the maximum burst time. If a burst would run past that limit, it is cut short and an error pulse is raised.

Top module: `psram_wr_ctrl`

## Requirements
- R1: After reset, `req_ready` is high while the controller is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the chip-select gap has elapsed, and no request is taken while it is low.
- R2: In the cycle after acceptance, `mem_cs_n`, `mem_adv_n` and `mem_we_n` are all low and `mem_addr` equals the accepted address. `mem_adv_n` is low for that one cycle only.
- R3: The first data word is driven (`mem_dq_oe` high) LATENCY cycles after the address-strobe cycle (default 5). The following words come in consecutive cycles.
- R4: A burst carries BURST_LEN words (default 4) of 16 bits. Word i is taken from `req_data[16*i +: 16]` and appears on `mem_dq` in slot i, in ascending order.
- R5: During word slot i, `mem_lb_n` equals the inverse of `req_be[2*i]` and `mem_ub_n` equals the inverse of `req_be[2*i+1]` (a set bit means the byte is written). Outside word slots both strobes are high.
- R6: A word whose two byte-enable bits are both 0 keeps its slot, and both strobes stay high for that slot. The words after it keep their timing.
- R7: `mem_we_n` is low from the address-strobe cycle through the last word and high once chip select is released. `mem_oe_n` is always high.
- R8: `mem_cs_n` goes high in the cycle after the last word. It stays high for GAP_CYC cycles, where GAP_CYC is the minimum gap rounded up to whole clocks and is at least 1. Only then does `req_ready` return high.
- R9: Chip select is low for no more than MAX_CYC = MAX_BURST_PS / CLK_PERIOD_PS consecutive cycles. If that count is reached before the last word, chip select goes high in the next cycle, no further words are driven, and `burst_err` is high for exactly that one cycle. Otherwise `burst_err` stays low.
- R10: During and right after reset, `mem_cs_n`, `mem_adv_n`, `mem_we_n`, `mem_ub_n` and `mem_lb_n` are high, and `mem_dq_oe` and `burst_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present on the user port |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Burst start address |
| req_data | input | BURST_LEN*DATA_W | Burst words, word 0 in the low bits |
| req_be | input | BURST_LEN*2 | Byte enables, two per word, low byte first, 1 = write |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, held inactive |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_dq | output | DATA_W | Write data bus |
| mem_dq_oe | output | 1 | Data bus drive enable, high in word slots |
| burst_err | output | 1 | One-cycle pulse when a burst is cut at the time limit |

## Verification
The bench sends four bursts, each with its own data and strobe pattern:
- The first writes every byte with distinct words, which separates word order from latency errors.
- The second clears both enables of the third word and one enable each of two other words. This separates a suppressed slot from a dropped or shifted one, and shows whether the upper and lower strobes are swapped.
- The third is raised while the previous burst is still in flight, which exposes a handshake that accepts during the gap.
- The fourth masks every word at the highest address.

A second instance uses a clock-period parameter whose limit falls short of a full burst. It shows whether the cut happens at the right cycle, whether any word leaks out, and whether the error pulse lines up with chip-select release.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_LAT,
      ST_DATA,
      ST_GAP
   } wr_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psram_wr_seq.sv
module psram_wr_seq
   import psram_wr_pkg::*;
#(
   parameter int LATENCY   = 5,
   parameter int BURST_LEN = 4,
   parameter int GAP_CYC   = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_fire,
   input  logic                         abort,
   output wr_state_e                    state,
   output logic [$clog2(BURST_LEN)-1:0] beat_idx
);

   localparam int BW = $clog2(BURST_LEN);
   localparam int CW = $clog2(max2(max2(LATENCY, BURST_LEN), GAP_CYC) + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (req_fire) state <= ST_CMD;
            end
            ST_CMD: begin
               if (abort) begin
                  state <= ST_GAP;
                  cnt   <= '0;
               end else if (LATENCY > 1) begin
                  state <= ST_LAT;
                  cnt   <= CW'(1);
               end else begin
                  state <= ST_DATA;
                  cnt   <= '0;
               end
            end
            ST_LAT: begin
               if (abort) begin
                  state <= ST_GAP;
                  cnt   <= '0;
               end else if (cnt == CW'(LATENCY - 1)) begin
                  state <= ST_DATA;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt == CW'(BURST_LEN - 1) || abort) begin
                  state <= ST_GAP;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_GAP: begin
               if (cnt == CW'(GAP_CYC - 1)) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= ST_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign beat_idx = cnt[BW-1:0];

endmodule

// File: rtl/psram_wr_limit.sv
module psram_wr_limit #(
   parameter int MAX_CYC = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_low,
   input  logic last_beat,
   output logic abort,
   output logic err
);

   localparam int TW = $clog2(MAX_CYC + 1);

   logic [TW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (!cs_low) begin
         low_cnt <= '0;
      end else if (low_cnt != TW'(MAX_CYC)) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   assign abort = cs_low && (low_cnt == TW'(MAX_CYC - 1)) && !last_beat;

   always_ff @(posedge clk) begin
      if (!rst_n) err <= 1'b0;
      else        err <= abort;
   end

endmodule

// File: rtl/psram_wr_beat.sv
module psram_wr_beat #(
   parameter int ADDR_W    = 22,
   parameter int DATA_W    = 16,
   parameter int BURST_LEN = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_fire,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [BURST_LEN*DATA_W-1:0]   req_data,
   input  logic [BURST_LEN*2-1:0]        req_be,
   input  logic                          in_data,
   input  logic [$clog2(BURST_LEN)-1:0]  beat_idx,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [DATA_W-1:0]             mem_dq,
   output logic                          mem_ub_n,
   output logic                          mem_lb_n
);

   logic [BURST_LEN*DATA_W-1:0] data_q;
   logic [BURST_LEN*2-1:0]      be_q;
   logic [DATA_W-1:0]           word_a [BURST_LEN];
   logic [1:0]                  be_a   [BURST_LEN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr <= '0;
         data_q   <= '0;
         be_q     <= '0;
      end else if (req_fire) begin
         mem_addr <= req_addr;
         data_q   <= req_data;
         be_q     <= req_be;
      end
   end

   for (genvar gi = 0; gi < BURST_LEN; gi++) begin : g_slot
      assign word_a[gi] = data_q[gi*DATA_W +: DATA_W];
      assign be_a[gi]   = be_q[gi*2 +: 2];
   end

   assign mem_dq   = in_data ? word_a[beat_idx] : '0;
   assign mem_lb_n = !(in_data && be_a[beat_idx][0]);
   assign mem_ub_n = !(in_data && be_a[beat_idx][1]);

endmodule

// File: rtl/psram_wr_ctrl.sv
module psram_wr_ctrl
   import psram_wr_pkg::*;
#(
   parameter int ADDR_W        = 22,
   parameter int DATA_W        = 16,
   parameter int BURST_LEN     = 4,
   parameter int LATENCY       = 5,
   parameter int CLK_PERIOD_PS = 10000,
   parameter int MAX_BURST_PS  = 2500000,
   parameter int MIN_GAP_PS    = 5000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [BURST_LEN*DATA_W-1:0] req_data,
   input  logic [BURST_LEN*2-1:0]      req_be,
   output logic                        mem_cs_n,
   output logic                        mem_adv_n,
   output logic                        mem_we_n,
   output logic                        mem_oe_n,
   output logic                        mem_ub_n,
   output logic                        mem_lb_n,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [DATA_W-1:0]           mem_dq,
   output logic                        mem_dq_oe,
   output logic                        burst_err
);

   localparam int BW        = $clog2(BURST_LEN);
   localparam int MAX_CYC   = MAX_BURST_PS / CLK_PERIOD_PS;
   localparam int GAP_CYC   = max2(1, ceil_div(MIN_GAP_PS, CLK_PERIOD_PS));
   localparam int BURST_CYC = LATENCY + BURST_LEN;

   if (LATENCY < 1) begin : g_bad_lat
      $error("psram_wr_ctrl: LATENCY must be at least 1");
   end
   if (BURST_LEN < 2 || (1 << BW) != BURST_LEN) begin : g_bad_len
      $error("psram_wr_ctrl: BURST_LEN must be a power of two, at least 2");
   end
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("psram_wr_ctrl: DATA_W must be an even number of bits");
   end
   if (CLK_PERIOD_PS < 1 || MAX_CYC < 2) begin : g_bad_limit
      $error("psram_wr_ctrl: burst limit shorter than two clocks");
   end
   if (MAX_CYC < BURST_CYC) begin : g_short_limit
      $warning("psram_wr_ctrl: every burst will be cut at the time limit");
   end

   wr_state_e         state;
   logic [BW-1:0]     beat_idx;
   logic              req_fire;
   logic              cs_low;
   logic              in_data;
   logic              last_beat;
   logic              abort;

   assign req_ready = (state == ST_IDLE);
   assign req_fire  = req_valid && req_ready;
   assign cs_low    = (state == ST_CMD) || (state == ST_LAT) || (state == ST_DATA);
   assign in_data   = (state == ST_DATA);
   assign last_beat = in_data && (beat_idx == BW'(BURST_LEN - 1));

   psram_wr_seq #(
      .LATENCY   (LATENCY),
      .BURST_LEN (BURST_LEN),
      .GAP_CYC   (GAP_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_fire (req_fire),
      .abort    (abort),
      .state    (state),
      .beat_idx (beat_idx)
   );

   psram_wr_limit #(
      .MAX_CYC (MAX_CYC)
   ) u_limit (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_low    (cs_low),
      .last_beat (last_beat),
      .abort     (abort),
      .err       (burst_err)
   );

   psram_wr_beat #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .BURST_LEN (BURST_LEN)
   ) u_beat (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_fire (req_fire),
      .req_addr (req_addr),
      .req_data (req_data),
      .req_be   (req_be),
      .in_data  (in_data),
      .beat_idx (beat_idx),
      .mem_addr (mem_addr),
      .mem_dq   (mem_dq),
      .mem_ub_n (mem_ub_n),
      .mem_lb_n (mem_lb_n)
   );

   assign mem_cs_n  = !cs_low;
   assign mem_adv_n = (state != ST_CMD);
   assign mem_we_n  = !cs_low;
   assign mem_oe_n  = 1'b1;
   assign mem_dq_oe = in_data;

endmodule

// File: rtl/psram_wr_ctrl_chk.sv
module psram_wr_ctrl_chk #(
   parameter int LATENCY = 5,
   parameter int MAX_CYC = 250
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic adv_n,
   input logic we_n,
   input logic ub_n,
   input logic lb_n,
   input logic dq_oe,
   input logic ready,
   input logic burst_err
);

   localparam int CW = $clog2(MAX_CYC + 1);
   localparam int SW = $clog2(LATENCY + 2);

   logic [CW-1:0] cs_cnt;
   logic [SW-1:0] since_adv;

   always_ff @(posedge clk) begin
      if (!rst_n || cs_n)                    cs_cnt <= '0;
      else if (cs_cnt != CW'(MAX_CYC))       cs_cnt <= cs_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || cs_n)                    since_adv <= '0;
      else if (!adv_n)                       since_adv <= SW'(1);
      else if (since_adv != SW'(LATENCY + 1)) since_adv <= since_adv + 1'b1;
   end

   p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> cs_n);
   p_adv_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_n |-> (!cs_n && !we_n));
   p_adv_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_n |=> adv_n);
   p_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> (since_adv == SW'(LATENCY)));
   p_be_in_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ub_n || !lb_n) |-> dq_oe);
   p_we_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!we_n && !cs_n));
   p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> !ready);
   p_burst_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> (cs_cnt < CW'(MAX_CYC)));
   p_err_at_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      burst_err |-> $rose(cs_n));

endmodule

bind psram_wr_ctrl psram_wr_ctrl_chk #(
   .LATENCY (LATENCY),
   .MAX_CYC (MAX_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (mem_cs_n),
   .adv_n     (mem_adv_n),
   .we_n      (mem_we_n),
   .ub_n      (mem_ub_n),
   .lb_n      (mem_lb_n),
   .dq_oe     (mem_dq_oe),
   .ready     (req_ready),
   .burst_err (burst_err)
);

// File: tb/psram_wr_ctrl_tb.sv
`timescale 1ns/1ps
module psram_wr_ctrl_tb;

   localparam int AW  = 22;
   localparam int DW  = 16;
   localparam int BL  = 4;
   localparam int LAT = 5;
   localparam int GAP = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [AW-1:0]     req_addr = '0;
   logic [BL*DW-1:0]  req_data = '0;
   logic [BL*2-1:0]   req_be = '0;
   logic cs_n, adv_n, we_n, oe_n, ub_n, lb_n, dq_oe, err;
   logic [AW-1:0]     mem_addr;
   logic [DW-1:0]     mem_dq;

   psram_wr_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
      .mem_cs_n(cs_n), .mem_adv_n(adv_n), .mem_we_n(we_n), .mem_oe_n(oe_n),
      .mem_ub_n(ub_n), .mem_lb_n(lb_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
      .mem_dq_oe(dq_oe), .burst_err(err)
   );

   // limit instance: 500 ns clock period parameter gives a 5-cycle cap
   logic              l_valid = 1'b0;
   logic              l_ready, l_cs_n, l_adv_n, l_we_n, l_oe_n, l_ub_n, l_lb_n, l_dq_oe, l_err;
   logic [AW-1:0]     l_addr;
   logic [DW-1:0]     l_dq;

   psram_wr_ctrl #(.CLK_PERIOD_PS(500000)) u_dut_lim (
      .clk(clk), .rst_n(rst_n), .req_valid(l_valid), .req_ready(l_ready),
      .req_addr(22'h1234), .req_data(64'h4444_3333_2222_1111), .req_be(8'hFF),
      .mem_cs_n(l_cs_n), .mem_adv_n(l_adv_n), .mem_we_n(l_we_n), .mem_oe_n(l_oe_n),
      .mem_ub_n(l_ub_n), .mem_lb_n(l_lb_n), .mem_addr(l_addr), .mem_dq(l_dq),
      .mem_dq_oe(l_dq_oe), .burst_err(l_err)
   );

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;
   int cyc     = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [AW-1:0]   addr_q [$];
   logic [DW+1:0]   beat_q [$];   // {ub_n, lb_n, word}

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   task automatic send(input logic [AW-1:0] a, input logic [BL*DW-1:0] d, input logic [BL*2-1:0] be);
      addr_q.push_back(a);
      for (int i = 0; i < BL; i++)
         beat_q.push_back({!be[2*i+1], !be[2*i], d[i*DW +: DW]});
      @(negedge clk);
      req_addr  = a;
      req_data  = d;
      req_be    = be;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      chk(!req_ready, "R1 ready drops after accept", req_ready, 0);
   endtask

   // scoreboard monitor
   bit mon_en = 1'b0;
   bit prev_cs = 1'b1, prev_ready = 1'b1, seen_rise = 1'b0;
   int t_adv = 0, bi = 0, t_rise = 0;
   always @(negedge clk) if (mon_en) begin
      if (!adv_n) begin
         chk(!cs_n && !we_n, "R2 strobes low with address", {cs_n, we_n}, 0);
         if (addr_q.size() == 0) chk(0, "R2 unexpected burst", mem_addr, 0);
         else begin
            logic [AW-1:0] ea;
            ea = addr_q.pop_front();
            chk(mem_addr == ea, "R2 address", mem_addr, ea);
         end
         chk(oe_n, "R7 output enable inactive", oe_n, 1);
         t_adv = cyc;
         bi = 0;
      end
      if (dq_oe) begin
         chk(cyc == t_adv + LAT + bi, "R3 word slot timing", cyc - t_adv, LAT + bi);
         chk(!we_n, "R7 write enable held", we_n, 0);
         if (beat_q.size() == 0) chk(0, "R4 extra word", mem_dq, 0);
         else begin
            logic [DW+1:0] eb;
            eb = beat_q.pop_front();
            chk({ub_n, lb_n, mem_dq} == eb, "R4/R5/R6 word and strobes", {ub_n, lb_n, mem_dq}, eb);
         end
         bi++;
      end else if (!ub_n || !lb_n) begin
         chk(0, "R5 strobe outside word slot", {ub_n, lb_n}, 2'b11);
      end
      if (cs_n && !prev_cs) begin
         chk(bi == BL, "R8 release after last word", bi, BL);
         chk(cyc == t_adv + LAT + BL, "R8 release cycle", cyc - t_adv, LAT + BL);
         chk(!req_ready, "R8 ready low in gap", req_ready, 0);
         chk(we_n, "R7 write enable released", we_n, 1);
         chk(!err, "R9 no error on a burst inside the limit", err, 0);
         t_rise = cyc;
         seen_rise = 1'b1;
      end
      if (req_ready && !prev_ready && seen_rise)
         chk(cyc - t_rise == GAP, "R8 gap length", cyc - t_rise, GAP);
      prev_cs = cs_n;
      prev_ready = req_ready;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({cs_n, adv_n, we_n, ub_n, lb_n, dq_oe, err} == 7'b1111100, "R10 outputs in reset",
          {cs_n, adv_n, we_n, ub_n, lb_n, dq_oe, err}, 7'b1111100);
      rst_n = 1'b1;
      @(negedge clk);
      chk({cs_n, adv_n, we_n, ub_n, lb_n, dq_oe, err} == 7'b1111100, "R10 outputs after reset",
          {cs_n, adv_n, we_n, ub_n, lb_n, dq_oe, err}, 7'b1111100);
      chk(req_ready, "R1 ready when idle", req_ready, 1);
      mon_en = 1'b1;

      // all bytes written, distinct words
      send(22'h000100, 64'hD003_C002_B001_A000, 8'hFF);
      // third word fully masked, word 0 low only, word 3 high only
      send(22'h02AB54, 64'h7777_6666_5555_4444, 8'b10_00_11_01);
      // raised while the previous burst is still running
      send(22'h155555, 64'h0F0F_F0F0_00FF_FF00, 8'b01_11_10_11);
      // every word masked at the top address
      send(22'h3FFFFF, 64'hFFFF_EEEE_DDDD_CCCC, 8'h00);

      while (beat_q.size() != 0 || !cs_n) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(addr_q.size() == 0, "R2 every command seen", addr_q.size(), 0);

      // time-limit cut on the second instance
      begin
         int low = 0, beats = 0, errs = 0;
         bit pcs = 1'b1;
         while (!l_ready) @(negedge clk);
         l_valid = 1'b1;
         @(posedge clk);
         #1 l_valid = 1'b0;
         for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (!l_cs_n) low++;
            if (l_dq_oe) beats++;
            if (l_err) begin
               errs++;
               chk(l_cs_n && !pcs, "R9 error with chip-select release", {l_cs_n, pcs}, 2'b10);
            end
            pcs = l_cs_n;
         end
         chk(low == 5, "R9 chip select low cycles at limit", low, 5);
         chk(beats == 0, "R9 no words after cut", beats, 0);
         chk(errs == 1, "R9 single error pulse", errs, 1);
         chk(l_ready && l_oe_n, "R8 limit instance idle again", {l_ready, l_oe_n}, 2'b11);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule